// File: doc/BRIEF.md
# Single-Bus 8-Bit CPU Datapath

This block holds every storage and arithmetic element of a minimal accumulator CPU, with all of them joined by one shared 8-bit bus. It has a 4-bit program counter, a 4-bit memory address register, a 16-word by 8-bit RAM, an 8-bit instruction register, an accumulator A, a B register and an add/subtract ALU. A separate control unit, which is not part of this block, sequences the micro-operations. On every clock it raises one bit of a one-hot source select to choose the bus driver. It also raises the load strobes of the registers that should capture the bus.

The instruction register sends its upper nibble to the control unit as the opcode. It drives only its lower nibble, the operand address, back onto the bus. The bus also serves three more transfers:

- memory loads into A or into B,
- stores from A back into RAM,
- jumps that load the program counter from the operand.

A debug source puts an external byte on the bus, so the MAR and the RAM can be filled before the program runs.

The outputs give a view of the PC, MAR, IR, A, B and the live bus value.

Top module: `sbus_datapath`

## Requirements
- R1: A clock edge with `rst_n` low clears PC, MAR, IR, A and B to zero.
- R2: The PC has three update rules, in priority order:
  - `pc_clr` clears the PC.
  - Otherwise `pc_load` loads the PC from bus bits [3:0].
  - Otherwise `pc_inc` adds one to the PC, wrapping from 15 to 0.
  - With none of the three high, the PC holds.
- R3: `bus_src` is one-hot, and the bits map to drivers as follows:
  - bit0 drives {0000, PC}.
  - bit1 drives RAM[MAR].
  - bit2 drives IR operand.
  - bit3 drives A.
  - bit4 drives ALU.
  - bit5 drives `dbg_data`.

  When no bit is set the bus reads 0x00. At most one bit may be set.
- R4: `ld_mar` loads the MAR from bus bits [3:0].
- R5: The RAM reads and writes at the address held in the MAR:
  - Selecting the RAM source places RAM[MAR] on the bus in the same cycle.
  - `ram_wr` writes the bus value into RAM[MAR] at the clock edge.
- R6: `ld_ir` loads all 8 bus bits into the IR. The `opcode` output equals IR[7:4]. The IR source drives {0000, IR[3:0]}.
- R7: Selecting the ALU source drives (A+B) mod 256, or (A−B) mod 256 when `alu_sub` is 1. With `ld_a` high, A captures that value.
- R8: `ld_b` loads B from the bus. The A source drives the value of A.
- R9: A jump, meaning the IR source together with `pc_load`, sets the PC to the operand nibble.
- R10: The debug source drives `dbg_data` onto the bus, and this is the only way the RAM and MAR are filled from outside.
- R11: The data words are 0x33 at address 13 and 0x19 at address 14. The program 1D 2E 30 5F F0 is run with opcodes 1=load A, 2=load B, 3=add, 4=subtract, 5=store, 6=jump, F=halt. It leaves 0x4C in A and at address 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_src | input | 6 | One-hot bus source select |
| dbg_data | input | 8 | External byte for the debug source |
| ld_mar | input | 1 | MAR load strobe |
| ld_ir | input | 1 | IR load strobe |
| ld_a | input | 1 | Accumulator load strobe |
| ld_b | input | 1 | B register load strobe |
| ram_wr | input | 1 | RAM write strobe |
| pc_inc | input | 1 | PC increment enable |
| pc_load | input | 1 | PC load from bus (jump) |
| pc_clr | input | 1 | PC clear |
| alu_sub | input | 1 | ALU subtract select |
| opcode | output | 4 | IR upper nibble |
| pc_q | output | 4 | Program counter view |
| mar_q | output | 4 | MAR view |
| ir_q | output | 8 | IR view |
| a_q | output | 8 | Accumulator view |
| b_q | output | 8 | B register view |
| bus_q | output | 8 | Bus value |

## Verification
The bench steps the PC through 15 to 0 and asserts clear, load and increment together. A wrong priority or a missing wrap shows up as a stray PC value. It subtracts a larger value from a smaller one and adds values that overflow, so an ALU with carry leakage or the wrong operand order returns a value other than 0xE6 or 0x10. It loads an IR with a nonzero upper nibble and checks that only the operand reaches the bus; a design that leaks the opcode would corrupt MAR and jump targets. Finally it runs add, subtract and jump programs with a sequencer written in the bench, and reads address 15 back through the RAM source.

// File: rtl/sbus_pkg.sv
// Shared widths and bus source indices for the single-bus datapath.
// Assumes the bus source select is one-hot with one bit per source below.
package sbus_pkg;
    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 4;
    localparam int NSRC    = 6;
    localparam int SRC_PC  = 0;
    localparam int SRC_RAM = 1;
    localparam int SRC_IR  = 2;
    localparam int SRC_A   = 3;
    localparam int SRC_ALU = 4;
    localparam int SRC_DBG = 5;
endpackage

// File: rtl/sbus_reg.sv
// Generic load-enabled register with synchronous active-low reset.
// Assumes the load enable is sampled at the rising clock edge.
module sbus_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Capture d when enabled; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (en) q <= d;
    end
endmodule

// File: rtl/sbus_pc.sv
// Program counter: clear beats load beats increment; wraps modulo 2**AW.
// Assumes load_val is the low bits of the shared bus.
module sbus_pc #(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          load,
    input  logic          inc,
    input  logic [AW-1:0] load_val,
    output logic [AW-1:0] q
);
    localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

    // Update the counter according to the priority of its controls.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) q <= '0;
        else if (load)     q <= load_val;
        else if (inc)      q <= q + ONE;
    end
endmodule

// File: rtl/sbus_ram.sv
// Small RAM: asynchronous read, synchronous write at one shared address.
// Assumes contents are not cleared by reset; software fills them first.
module sbus_ram #(
    parameter int AW = 4,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Write the bus value into the addressed word.
    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
    end

    // Present the addressed word combinationally.
    always_comb rdata = mem[addr];
endmodule

// File: rtl/sbus_alu.sv
// Add/subtract unit; result wraps modulo 2**DW, no flags kept.
// Assumes both operands come straight from the A and B registers.
module sbus_alu #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          sub,
    output logic [DW-1:0] y
);
    // Select sum or difference.
    always_comb y = sub ? (a - b) : (a + b);
endmodule

// File: rtl/sbus_busmux.sv
// AND-OR bus multiplexer; with no select bit the bus reads zero.
// Assumes sel is one-hot or zero; multiple bits would OR the sources.
module sbus_busmux #(
    parameter int DW = 8,
    parameter int N  = 6
) (
    input  logic [N-1:0][DW-1:0] src,
    input  logic [N-1:0]         sel,
    output logic [DW-1:0]        bus
);
    logic [N:0][DW-1:0] acc;

    assign acc[0] = '0;
    for (genvar g = 0; g < N; g++) begin : g_or
        assign acc[g+1] = acc[g] | (src[g] & {DW{sel[g]}});
    end
    assign bus = acc[N];
endmodule

// File: rtl/sbus_datapath.sv
// Single-bus CPU datapath: PC, MAR, RAM, IR, A, B and ALU on one bus.
// Assumes an external control unit gives a one-hot source and load strobes.
module sbus_datapath
    import sbus_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] bus_src,
    input  logic [DW-1:0]   dbg_data,
    input  logic            ld_mar,
    input  logic            ld_ir,
    input  logic            ld_a,
    input  logic            ld_b,
    input  logic            ram_wr,
    input  logic            pc_inc,
    input  logic            pc_load,
    input  logic            pc_clr,
    input  logic            alu_sub,
    output logic [DW-AW-1:0] opcode,
    output logic [AW-1:0]   pc_q,
    output logic [AW-1:0]   mar_q,
    output logic [DW-1:0]   ir_q,
    output logic [DW-1:0]   a_q,
    output logic [DW-1:0]   b_q,
    output logic [DW-1:0]   bus_q
);
    localparam int PADW = DW - AW;

    logic [NSRC-1:0][DW-1:0] src_data;
    logic [DW-1:0]           ram_rd;
    logic [DW-1:0]           alu_y;
    logic [DW-1:0]           bus;

    assign src_data[SRC_PC]  = {{PADW{1'b0}}, pc_q};
    assign src_data[SRC_RAM] = ram_rd;
    assign src_data[SRC_IR]  = {{PADW{1'b0}}, ir_q[AW-1:0]};
    assign src_data[SRC_A]   = a_q;
    assign src_data[SRC_ALU] = alu_y;
    assign src_data[SRC_DBG] = dbg_data;

    sbus_busmux #(.DW(DW), .N(NSRC)) u_mux (
        .src (src_data),
        .sel (bus_src),
        .bus (bus)
    );

    sbus_pc #(.AW(AW)) u_pc (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (pc_clr),
        .load     (pc_load),
        .inc      (pc_inc),
        .load_val (bus[AW-1:0]),
        .q        (pc_q)
    );

    sbus_reg #(.W(AW)) u_mar (
        .clk (clk), .rst_n (rst_n), .en (ld_mar), .d (bus[AW-1:0]), .q (mar_q)
    );

    sbus_reg #(.W(DW)) u_ir (
        .clk (clk), .rst_n (rst_n), .en (ld_ir), .d (bus), .q (ir_q)
    );

    sbus_reg #(.W(DW)) u_a (
        .clk (clk), .rst_n (rst_n), .en (ld_a), .d (bus), .q (a_q)
    );

    sbus_reg #(.W(DW)) u_b (
        .clk (clk), .rst_n (rst_n), .en (ld_b), .d (bus), .q (b_q)
    );

    sbus_ram #(.AW(AW), .DW(DW)) u_ram (
        .clk   (clk),
        .we    (ram_wr),
        .addr  (mar_q),
        .wdata (bus),
        .rdata (ram_rd)
    );

    sbus_alu #(.DW(DW)) u_alu (
        .a   (a_q),
        .b   (b_q),
        .sub (alu_sub),
        .y   (alu_y)
    );

    assign opcode = ir_q[DW-1:AW];
    assign bus_q  = bus;
endmodule

// File: rtl/sbus_chk.sv
// Property checker for the single-bus datapath, attached by bind.
// Assumes it sees only the ports of the datapath.
module sbus_chk
    import sbus_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NSRC-1:0] bus_src,
    input logic            alu_sub,
    input logic            pc_clr,
    input logic            pc_inc,
    input logic            pc_load,
    input logic            ld_mar,
    input logic            ld_a,
    input logic            ld_b,
    input logic [DW-1:0]   bus_q,
    input logic [AW-1:0]   pc_q,
    input logic [AW-1:0]   mar_q,
    input logic [DW-1:0]   ir_q,
    input logic [DW-1:0]   a_q,
    input logic [DW-1:0]   b_q
);
    localparam logic [NSRC-1:0] SEL_IR  = NSRC'(1) << SRC_IR;
    localparam logic [NSRC-1:0] SEL_ALU = NSRC'(1) << SRC_ALU;
    localparam logic [AW-1:0]   ONE     = {{(AW-1){1'b0}}, 1'b1};

    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (pc_q == '0 && mar_q == '0 && ir_q == '0 && a_q == '0 && b_q == '0));

    p_src_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bus_src));

    p_idle_bus_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_src == '0) |-> (bus_q == '0));

    p_pc_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pc_clr |=> (pc_q == '0));

    p_pc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_inc && !pc_load && !pc_clr) |=> (pc_q == $past(pc_q) + ONE));

    p_pc_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!pc_inc && !pc_load && !pc_clr) |=> $stable(pc_q));

    p_jump_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_load && !pc_clr) |=> (pc_q == $past(bus_q[AW-1:0])));

    p_mar_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ld_mar |=> (mar_q == $past(bus_q[AW-1:0])));

    p_ir_operand_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_src == SEL_IR) |-> (bus_q == {{(DW-AW){1'b0}}, ir_q[AW-1:0]}));

    p_alu_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_src == SEL_ALU) |-> (bus_q == (alu_sub ? DW'(a_q - b_q) : DW'(a_q + b_q))));

    p_a_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ld_a |=> (a_q == $past(bus_q)));

    p_b_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ld_b |=> (b_q == $past(bus_q)));
endmodule

bind sbus_datapath sbus_chk #(.DW(DW), .AW(AW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .bus_src (bus_src),
    .alu_sub (alu_sub),
    .pc_clr  (pc_clr),
    .pc_inc  (pc_inc),
    .pc_load (pc_load),
    .ld_mar  (ld_mar),
    .ld_a    (ld_a),
    .ld_b    (ld_b),
    .bus_q   (bus_q),
    .pc_q    (pc_q),
    .mar_q   (mar_q),
    .ir_q    (ir_q),
    .a_q     (a_q),
    .b_q     (b_q)
);

// File: tb/sim_sbus_datapath.sv
// Directed bench for the single-bus datapath; acts as its own sequencer.
module sim_sbus_datapath;
    localparam logic [5:0] S_NONE = 6'b000000;
    localparam logic [5:0] S_PC   = 6'b000001;
    localparam logic [5:0] S_RAM  = 6'b000010;
    localparam logic [5:0] S_IR   = 6'b000100;
    localparam logic [5:0] S_A    = 6'b001000;
    localparam logic [5:0] S_ALU  = 6'b010000;
    localparam logic [5:0] S_DBG  = 6'b100000;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [5:0] bus_src;
    logic [7:0] dbg_data;
    logic       ld_mar, ld_ir, ld_a, ld_b, ram_wr;
    logic       pc_inc, pc_load, pc_clr, alu_sub;
    logic [3:0] opcode, pc_q, mar_q;
    logic [7:0] ir_q, a_q, b_q, bus_q;

    int nvec = 0;
    int nerr = 0;

    always #5 clk = ~clk;

    sbus_datapath u0 (
        .clk (clk), .rst_n (rst_n), .bus_src (bus_src), .dbg_data (dbg_data),
        .ld_mar (ld_mar), .ld_ir (ld_ir), .ld_a (ld_a), .ld_b (ld_b),
        .ram_wr (ram_wr), .pc_inc (pc_inc), .pc_load (pc_load),
        .pc_clr (pc_clr), .alu_sub (alu_sub), .opcode (opcode),
        .pc_q (pc_q), .mar_q (mar_q), .ir_q (ir_q), .a_q (a_q),
        .b_q (b_q), .bus_q (bus_q)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        nvec++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        bus_src = S_NONE; dbg_data = 8'h00;
        ld_mar = 0; ld_ir = 0; ld_a = 0; ld_b = 0; ram_wr = 0;
        pc_inc = 0; pc_load = 0; pc_clr = 0; alu_sub = 0;
    endtask

    // One clock edge, then return 1 ns later with controls cleared.
    task automatic step();
        @(posedge clk);
        #1;
        idle();
    endtask

    task automatic dbg_reg(input logic [7:0] v, input int which);
        bus_src = S_DBG; dbg_data = v;
        case (which)
            0: ld_mar = 1;
            1: ld_ir  = 1;
            2: ld_a   = 1;
            default: ld_b = 1;
        endcase
        step();
    endtask

    task automatic dbg_write(input logic [3:0] addr, input logic [7:0] data);
        dbg_reg({4'h0, addr}, 0);
        bus_src = S_DBG; dbg_data = data; ram_wr = 1;
        step();
    endtask

    task automatic peek(input string req, input logic [3:0] addr, input logic [7:0] exp);
        dbg_reg({4'h0, addr}, 0);
        bus_src = S_RAM;
        #1;
        chk(req, bus_q, exp);
        idle();
    endtask

    task automatic t_reset();
        dbg_reg(8'h55, 2);
        dbg_reg(8'hAA, 3);
        dbg_reg(8'h9C, 1);
        dbg_reg(8'h07, 0);
        pc_inc = 1; step();
        rst_n = 0; step(); rst_n = 1;
        chk("R1 pc", {4'h0, pc_q}, 8'h00);
        chk("R1 mar", {4'h0, mar_q}, 8'h00);
        chk("R1 ir", ir_q, 8'h00);
        chk("R1 a", a_q, 8'h00);
        chk("R1 b", b_q, 8'h00);
    endtask

    task automatic t_bus();
        #1;
        chk("R3 idle bus", bus_q, 8'h00);
        pc_inc = 1; step(); pc_inc = 1; step(); pc_inc = 1; step();
        bus_src = S_PC; #1;
        chk("R3 pc source", bus_q, 8'h03);
        idle();
        bus_src = S_DBG; dbg_data = 8'hC5; #1;
        chk("R10 debug source", bus_q, 8'hC5);
        idle();
    endtask

    task automatic t_pc();
        pc_clr = 1; step();
        for (int i = 0; i < 15; i++) begin
            pc_inc = 1; step();
        end
        chk("R2 pc at 15", {4'h0, pc_q}, 8'h0F);
        pc_inc = 1; step();
        chk("R2 pc wrap", {4'h0, pc_q}, 8'h00);
        bus_src = S_DBG; dbg_data = 8'hF9; pc_load = 1; pc_inc = 1; step();
        chk("R2 load over inc", {4'h0, pc_q}, 8'h09);
        bus_src = S_DBG; dbg_data = 8'h04; pc_load = 1; pc_inc = 1; pc_clr = 1; step();
        chk("R2 clear over load", {4'h0, pc_q}, 8'h00);
        step();
        chk("R2 pc holds", {4'h0, pc_q}, 8'h00);
    endtask

    task automatic t_ram();
        dbg_write(4'h0, 8'h11);
        dbg_write(4'h9, 8'hE7);
        dbg_write(4'hF, 8'h80);
        chk("R4 mar loads low nibble", {4'h0, mar_q}, 8'h0F);
        peek("R5 read addr 0", 4'h0, 8'h11);
        peek("R5 read addr 9", 4'h9, 8'hE7);
        dbg_write(4'h9, 8'h3C);
        peek("R5 overwrite addr 9", 4'h9, 8'h3C);
        peek("R5 addr 15 intact", 4'hF, 8'h80);
    endtask

    task automatic t_ir();
        dbg_reg(8'hA7, 1);
        chk("R6 ir full byte", ir_q, 8'hA7);
        chk("R6 opcode", {4'h0, opcode}, 8'h0A);
        bus_src = S_IR; #1;
        chk("R6 ir drives operand only", bus_q, 8'h07);
        idle();
        bus_src = S_IR; ld_mar = 1; step();
        chk("R4 mar from ir operand", {4'h0, mar_q}, 8'h07);
        bus_src = S_IR; pc_load = 1; step();
        chk("R9 jump to operand", {4'h0, pc_q}, 8'h07);
    endtask

    task automatic t_alu();
        dbg_reg(8'hF0, 2);
        dbg_reg(8'h20, 3);
        chk("R8 b load", b_q, 8'h20);
        bus_src = S_A; #1;
        chk("R8 a source", bus_q, 8'hF0);
        idle();
        bus_src = S_ALU; #1;
        chk("R7 add wraps", bus_q, 8'h10);
        ld_a = 1; step();
        chk("R7 add into a", a_q, 8'h10);
        dbg_reg(8'h19, 2);
        dbg_reg(8'h33, 3);
        bus_src = S_ALU; alu_sub = 1; ld_a = 1; step();
        chk("R7 sub wraps below zero", a_q, 8'hE6);
        bus_src = S_ALU; alu_sub = 1; ld_a = 1; step();
        chk("R7 sub again", a_q, 8'hB3);
    endtask

    // Image bytes listed from address 0 at the most significant end.
    task automatic run_img(input string req, input logic [127:0] img,
                           input logic [7:0] exp_a, input logic [3:0] exp_pc);
        bit halted = 0;
        for (int i = 0; i < 16; i++) dbg_write(4'(i), img[127-8*i -: 8]);
        pc_clr = 1; step();
        for (int n = 0; n < 32 && !halted; n++) begin
            bus_src = S_PC;  ld_mar = 1; step();
            bus_src = S_RAM; ld_ir  = 1; step();
            pc_inc = 1; step();
            case (opcode)
                4'h1: begin
                    bus_src = S_IR;  ld_mar = 1; step();
                    bus_src = S_RAM; ld_a   = 1; step();
                end
                4'h2: begin
                    bus_src = S_IR;  ld_mar = 1; step();
                    bus_src = S_RAM; ld_b   = 1; step();
                end
                4'h3: begin bus_src = S_ALU; ld_a = 1; step(); end
                4'h4: begin bus_src = S_ALU; alu_sub = 1; ld_a = 1; step(); end
                4'h5: begin
                    bus_src = S_IR; ld_mar = 1; step();
                    bus_src = S_A;  ram_wr = 1; step();
                end
                4'h6: begin bus_src = S_IR; pc_load = 1; step(); end
                4'hF: halted = 1;
                default: ;
            endcase
        end
        chk({req, " halted"}, {7'h0, halted}, 8'h01);
        chk({req, " a result"}, a_q, exp_a);
        chk({req, " pc after halt"}, {4'h0, pc_q}, {4'h0, exp_pc});
        peek({req, " stored at 15"}, 4'hF, exp_a);
    endtask

    initial begin
        #(200000 * 10);
        nvec++; nerr++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

    initial begin
        idle();
        rst_n = 0;
        repeat (3) @(posedge clk);
        #1; rst_n = 1;
        t_reset();
        t_bus();
        t_pc();
        t_ram();
        t_ir();
        t_alu();
        run_img("R11 add program",
                128'h1D2E305FF0000000000000000033_1900, 8'h4C, 4'h5);
        run_img("R11 sub program",
                128'h1D2E405FF0000000000000000033_1900, 8'h1A, 4'h5);
        run_img("R11 jump program R9",
                128'h1D2E650000305FF00000000000331900, 8'h4C, 4'h8);
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end
endmodule